// File: doc/BRIEF.md
# SPI Flash Command Engine with Shared Ring Buffer

This block is a host-side SPI master that runs one complete flash command each time software asks it to. Software talks to it through a small byte-wide register bank. One register holds the opcode, and one packs the number of bytes to send and the number of bytes to receive. A control register starts a command and rewinds the buffer pointer. A data port reads and writes the buffer, and a status register shows the buffer pointer and the chosen serial clock rate.

Transmit and receive data live in a single eight-slot ring buffer that is never cleared. The opcode always goes out first, from its own register. After it, every byte is taken from the ring slot under the pointer and shifted out. The byte the flash returns in that time replaces it in the same slot, and the pointer then moves on. To collect a response, software rewinds the pointer, reads past the bytes it sent and then reads the answer. The count register keeps its value through the command, so software can read it afterwards to see whether another agent has disturbed the engine.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, and the opcode, count and status registers read 0x00. Control reads 0x00, the pointer is 0 and every ring slot holds 0x00.
- R2: The register offsets are fixed:
  - 0x0 is the opcode, read/write.
  - 0x1 is the counts: receive count in bits 7:4, transmit count (opcode excluded) in bits 3:0, read/write.
  - 0x2 is control: bit 0 starts a command, bit 4 rewinds the pointer.
  - 0xC is the ring data port.
  - 0xD is status: pointer in bits 2:0, speed select in bits 5:4 (writable), all other bits read 0.
- R3: Each data-port read or write while idle touches the slot under the pointer and then advances the pointer by one, modulo 8. Slot contents persist.
- R4: Writing 1 to control bit 0 while idle starts a command. Control bit 0 then reads 1 until the command ends. Writing 1 to control bit 4 while idle sets the pointer to 0.
- R5: A command drives spi_cs_n low and then sends the opcode, MSB first. It then sends tx+rx further bytes, each taken from the ring slot under the pointer, including stale slot contents during the receive phase. Timing is SPI mode 0: spi_sclk idles low, spi_mosi changes only while spi_sclk is low, and spi_miso is sampled on the rising edge.
- R6: The byte received during each post-opcode byte is written into the slot that byte came from, and the pointer then advances. The response to the opcode is dropped. At the end the pointer has advanced by tx+rx, modulo 8.
- R7: A command with transmit count 0 and receive count N clocks exactly 1+N bytes and stores all N responses, with none dropped at the end.
- R8: A count field above 8 is handled as 8 on the wire. The register still reads back the value that was written.
- R9: While a command runs, writes to the opcode, count, status and data port are ignored, data-port reads do not move the pointer, and control writes have no effect.
- R10: With speed select S (0..3), each spi_sclk high phase and each normal low phase lasts S+1 clock cycles.
- R11: A single control write with both bit 0 and bit 4 set rewinds the pointer to 0, and the command it starts uses slot 0 as its first data slot.
- R12: spi_cs_n returns high after the last bit of the last byte has been clocked, and the engine returns to idle at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; advances the pointer on the data port |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two functions can land on the same clock edge: the pointer rewind and the command start, when one control write sets both bit 0 and bit 4. The bench does this on alternate commands of the sweep, after writing the transmit bytes has left the pointer nonzero. It then judges the result on three things. The first data byte on the wire must be slot 0. The responses must land from slot 0 upward. The final pointer must equal the byte total modulo 8. The other commands issue the rewind and the start as separate writes, so a wrong ordering between the two shows up as a difference between the two halves of the sweep.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SHIFT = 2'd1,
        SQ_LOAD  = 2'd2
    } seq_st_e;

    localparam logic [3:0] A_OPCODE = 4'h0;
    localparam logic [3:0] A_COUNTS = 4'h1;
    localparam logic [3:0] A_CTRL   = 4'h2;
    localparam logic [3:0] A_DATA   = 4'hC;
    localparam logic [3:0] A_STATUS = 4'hD;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] sel,
    output logic             tick
);
    typedef struct packed { logic [DIV_W-1:0] cnt; } div_t;
    div_t d, q;

    always_comb begin
        d    = q;
        tick = en && (q.cnt == sel);
        if (!en || tick) d.cnt = '0;
        else             d.cnt = q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/spi_ring.sv
module spi_ring #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr,
    input  logic                     inc,
    input  logic [W-1:0]             wdata,
    output logic [W-1:0]             rdata,
    output logic [$clog2(DEPTH)-1:0] ptr
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           ptr;
    } ring_t;
    ring_t d, q;

    always_comb begin
        d = q;
        if (wr)  d.mem[q.ptr] = wdata;
        if (clr)      d.ptr = '0;
        else if (inc) d.ptr = q.ptr + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.mem[q.ptr];
    assign ptr   = q.ptr;

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> (q.ptr == $past(q.ptr)) || (q.ptr == $past(q.ptr) + PW'(1)));
endmodule

// File: rtl/spi_shift_seq.sv
module spi_shift_seq
    import spi_cmd_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [CNT_W-1:0] nbytes,
    input  logic             tick,
    input  logic             miso,
    input  logic [7:0]       ring_rd,
    output logic             busy,
    output logic             div_en,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    output logic             ring_wr,
    output logic             ring_inc,
    output logic [7:0]       ring_wdata
);
    typedef struct packed {
        seq_st_e          st;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic [2:0]       bitc;
        logic [CNT_W-1:0] left;
        logic             is_data;
        logic             sclk;
        logic             cs_n;
    } seq_t;
    seq_t d, q;

    always_comb begin
        d        = q;
        ring_wr  = 1'b0;
        ring_inc = 1'b0;
        case (q.st)
            SQ_IDLE: if (start) begin
                d.st      = SQ_SHIFT;
                d.sh      = opcode;
                d.bitc    = '0;
                d.left    = nbytes;
                d.is_data = 1'b0;
                d.cs_n    = 1'b0;
                d.sclk    = 1'b0;
            end
            SQ_SHIFT: if (tick) begin
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                    d.rx   = {q.rx[6:0], miso};
                end else begin
                    d.sclk = 1'b0;
                    if (q.bitc == 3'd7) begin
                        d.bitc = '0;
                        if (q.is_data) begin
                            ring_wr  = 1'b1;
                            ring_inc = 1'b1;
                        end
                        if (q.left == '0) begin
                            d.st   = SQ_IDLE;
                            d.cs_n = 1'b1;
                        end else begin
                            d.st      = SQ_LOAD;
                            d.left    = q.left - CNT_W'(1);
                            d.is_data = 1'b1;
                        end
                    end else begin
                        d.bitc = q.bitc + 3'd1;
                        d.sh   = {q.sh[6:0], 1'b0};
                    end
                end
            end
            SQ_LOAD: begin
                d.sh = ring_rd;
                d.st = SQ_SHIFT;
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= SQ_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != SQ_IDLE);
    assign div_en     = (q.st == SQ_SHIFT);
    assign sclk       = q.sclk;
    assign cs_n       = q.cs_n;
    assign mosi       = q.sh[7];
    assign ring_wdata = q.rx;

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> !q.sclk);
    // R12
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_IDLE) |-> q.cs_n);
    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int RING_DEPTH = 8,
    parameter int MAX_CNT    = 8,
    parameter int DIV_W      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int PW    = $clog2(RING_DEPTH);
    localparam int CNT_W = $clog2(2 * MAX_CNT + 1);

    typedef struct packed {
        logic [7:0]       op;
        logic [7:0]       cnt;
        logic [DIV_W-1:0] spd;
    } regs_t;
    regs_t d, q;

    logic             busy, tick, div_en;
    logic             seq_wr, seq_inc;
    logic [7:0]       seq_wdata, ring_rd;
    logic [PW-1:0]    ptr;
    logic             start, ptr_clr, port_wr, port_rd;
    logic [CNT_W-1:0] tx_eff, rx_eff;

    always_comb begin
        start   = bus_wr && !busy && (bus_addr == A_CTRL) && bus_wdata[0];
        ptr_clr = bus_wr && !busy && (bus_addr == A_CTRL) && bus_wdata[4];
        port_wr = bus_wr && !busy && (bus_addr == A_DATA);
        port_rd = bus_rd && !busy && (bus_addr == A_DATA);
        tx_eff  = (q.cnt[3:0] > 4'(MAX_CNT)) ? CNT_W'(MAX_CNT) : CNT_W'(q.cnt[3:0]);
        rx_eff  = (q.cnt[7:4] > 4'(MAX_CNT)) ? CNT_W'(MAX_CNT) : CNT_W'(q.cnt[7:4]);

        d = q;
        if (bus_wr && !busy) begin
            case (bus_addr)
                A_OPCODE: d.op  = bus_wdata;
                A_COUNTS: d.cnt = bus_wdata;
                A_STATUS: d.spd = bus_wdata[4 +: DIV_W];
                default:  ;
            endcase
        end

        case (bus_addr)
            A_OPCODE: bus_rdata = q.op;
            A_COUNTS: bus_rdata = q.cnt;
            A_CTRL:   bus_rdata = {7'b0, busy};
            A_DATA:   bus_rdata = ring_rd;
            A_STATUS: bus_rdata = {2'b0, 2'(q.spd), 1'b0, 3'(ptr)};
            default:  bus_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_ring #(.DEPTH(RING_DEPTH), .W(8)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ptr_clr),
        .wr    (seq_wr | port_wr),
        .inc   (seq_inc | port_wr | port_rd),
        .wdata (busy ? seq_wdata : bus_wdata),
        .rdata (ring_rd),
        .ptr   (ptr)
    );

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_en),
        .sel   (q.spd),
        .tick  (tick)
    );

    spi_shift_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .opcode     (q.op),
        .nbytes     (tx_eff + rx_eff),
        .tick       (tick),
        .miso       (spi_miso),
        .ring_rd    (ring_rd),
        .busy       (busy),
        .div_en     (div_en),
        .sclk       (spi_sclk),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .ring_wr    (seq_wr),
        .ring_inc   (seq_inc),
        .ring_wdata (seq_wdata)
    );

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.cnt));
    // R9
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.op));
endmodule

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    spi_cmd_engine u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // flash model
    int         seed_g = 0;
    int         bitn = 0, bytn = 0;
    logic [7:0] shv = 8'h00;
    logic [7:0] rcv [0:31];

    function automatic logic [7:0] resp(input int k);
        return 8'((k * 29 + seed_g * 7 + 8'h41) & 8'hFF);
    endfunction

    always @(negedge spi_cs_n) begin
        bitn = 0; bytn = 0;
        spi_miso = resp(0)[7];
    end
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        shv = {shv[6:0], spi_mosi};
        bitn = bitn + 1;
        if (bitn == 8) begin
            if (bytn < 32) rcv[bytn] = shv;
            bytn = bytn + 1;
            bitn = 0;
        end
    end
    always @(negedge spi_sclk) if (!spi_cs_n) spi_miso = resp(bytn)[7 - bitn];

    // sclk high-phase monitor
    int hcnt = 0, last_high = 0;
    always @(negedge clk) begin
        if (spi_sclk) hcnt = hcnt + 1;
        else if (hcnt != 0) begin last_high = hcnt; hcnt = 0; end
    end

    logic [7:0] exp_mem [0:7];

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic run_cmd(input logic [3:0] txf, input logic [3:0] rxf,
                           input int sel, input logic [7:0] op, input int sd, input bit both);
        logic [7:0] v;
        logic [7:0] sent [0:15];
        int txe, rxe, n, guard;
        txe = (txf > 8) ? 8 : int'(txf);
        rxe = (rxf > 8) ? 8 : int'(rxf);
        n = txe + rxe;
        seed_g = sd;
        wr(4'hD, 8'(sel << 4));
        wr(4'h2, 8'h10);
        for (int i = 0; i < txe; i++) begin
            v = 8'((sd + i * 7) ^ 8'h3C);
            wr(4'hC, v);
            exp_mem[i] = v;
        end
        wr(4'h1, {rxf, txf});
        wr(4'h0, op);
        last_high = 0;
        if (both) wr(4'h2, 8'h11);            // R11: rewind and start together
        else begin wr(4'h2, 8'h10); wr(4'h2, 8'h01); end
        rd(4'h2, v);
        chk("R4 busy after start", int'(v[0]), 1);
        // R9: writes while busy must be ignored
        wr(4'h1, 8'h00);
        wr(4'h0, 8'h00);
        wr(4'hC, 8'hEE);
        wr(4'hD, 8'h30);
        guard = 0;
        do begin rd(4'h2, v); guard++; end while (v[0] && guard < 5000);
        for (int j = 0; j < n; j++) begin
            sent[j] = exp_mem[j % 8];
            exp_mem[j % 8] = resp(j + 1);
        end
        chk("R12 cs_n released", int'(spi_cs_n), 1);
        chk("R7 bytes clocked", bytn, n + 1);
        chk("R5 opcode first", int'(rcv[0]), int'(op));
        for (int j = 0; j < n; j++)
            chk(both ? "R11 data byte on wire" : "R5 data byte on wire",
                int'(rcv[j + 1]), int'(sent[j]));
        chk("R10 sclk high phase", last_high, sel + 1);
        rd(4'hD, v);
        chk("R6 final pointer", int'(v[2:0]), n % 8);
        chk("R9 speed kept", int'(v[5:4]), sel);
        rd(4'h1, v);
        chk("R8 count register kept", int'(v), int'({rxf, txf}));
        rd(4'h0, v);
        chk("R9 opcode kept", int'(v), int'(op));
        wr(4'h2, 8'h10);
        for (int i = 0; i < 8; i++) begin
            rd(4'hC, v);
            chk("R6 ring slot", int'(v), int'(exp_mem[i]));
        end
        rd(4'hD, v);
        chk("R3 pointer wraps", int'(v[2:0]), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL R12 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 8; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 cs_n idle", int'(spi_cs_n), 1);
        chk("R1 sclk idle", int'(spi_sclk), 0);
        rd(4'h0, v); chk("R1 opcode", int'(v), 0);
        rd(4'h1, v); chk("R1 counts", int'(v), 0);
        rd(4'h2, v); chk("R1 control", int'(v), 0);
        rd(4'hD, v); chk("R1 status", int'(v), 0);
        // R2
        wr(4'h1, 8'hA5); rd(4'h1, v); chk("R2 count readback", int'(v), 'hA5);
        wr(4'h0, 8'h9F); rd(4'h0, v); chk("R2 opcode readback", int'(v), 'h9F);
        wr(4'hD, 8'hFF); rd(4'hD, v); chk("R2 status layout", int'(v), 'h30);
        // R3: ten port writes wrap the pointer to 2
        for (int i = 0; i < 10; i++) begin
            wr(4'hC, 8'(8'h10 + i));
            exp_mem[i % 8] = 8'(8'h10 + i);
        end
        rd(4'hD, v); chk("R3 pointer after 10 writes", int'(v[2:0]), 2);
        wr(4'h2, 8'h10);
        rd(4'hD, v); chk("R4 rewind", int'(v[2:0]), 0);
        rd(4'hC, v); chk("R3 slot0 persists", int'(v), 'h18);
        // sweep
        for (int t = 0; t <= 8; t++)
            for (int r = 0; r <= 8; r++)
                run_cmd(4'(t), 4'(r), (t + r) % 4, 8'(8'h03 + t * 16 + r), t * 9 + r, ((t + r) % 2) == 1);
        // R8: oversized fields
        run_cmd(4'hB, 4'h9, 1, 8'h0B, 77, 1'b0);
        run_cmd(4'h0, 4'hF, 3, 8'h9F, 78, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule